// File: doc/BRIEF.md
# Prefixed Shift Rotate Bit Unit

This unit carries out the second byte of a bit-manipulation instruction that follows a prefix byte. The byte names an operation and an operand. The operand is one of the seven 8-bit registers or the byte in memory at the address held in the H:L pair. The unit does rotates and shifts through or around the carry, a nibble exchange, a single-bit test, and clearing or setting one bit. It writes the result back to where the operand came from and updates the flag bits.

A sequencer raises `start` for one clock with the opcode byte. A register operand is read from a combinational register-file port and written back on the next clock, so the work completes one cycle after `start`. A memory operand becomes a read-modify-write. The unit issues a read at the H:L address, takes the byte one cycle later, and then writes the new value back. The result of that form arrives two cycles after `start`. `done` marks the cycle in which the write-back and the flag update are presented.

Top module: `bitop_exec`

## Requirements
- R1: Opcode bits 2:0 pick the operand: 0 B, 1 C, 2 D, 3 E, 4 H, 5 L, 6 memory at H:L, 7 A. A register form drives `rf_rd_sel` and `rf_wr_sel` with that code and asserts `done` in the cycle after the `start` cycle.
- R2: Opcodes 0x00-0x3F use bits 5:3 as follows:
  - 0: rotate left with bit 7 wrapping to bit 0.
  - 1: rotate right with bit 0 wrapping to bit 7.
  - 2: rotate left through carry, with the old C entering bit 0.
  - 3: rotate right through carry, with the old C entering bit 7.
  - 4: shift left, inserting 0.
  - 5: arithmetic shift right, keeping bit 7.
  - 6: exchange the nibbles.
  - 7: logical shift right, inserting 0.
- R3: The flag bus is {Z,N,H,C} on bits 3..0. For group R2, the new flags have Z set when the result is zero, N=0 and H=0. C takes the bit moved out, or 0 for the nibble exchange. `flags_wr_en` is high in the `done` cycle.
- R4: Opcodes 0x40-0x7F test bit number bits 5:3. The new flags are Z = inverse of that bit, N=0, H=1, C unchanged. No register or memory write occurs, so the operand is left unchanged.
- R5: Opcodes 0x80-0xBF clear, and 0xC0-0xFF set, bit number bits 5:3 of the operand and write it back. All four flags stay unchanged (`flags_wr_en` low).
- R6: For a memory form, `mem_rd_en` is high for the single cycle after `start`, with `mem_addr` equal to `hl_pair`. `mem_rd_data` is taken one cycle later. In that cycle `done` is asserted, together with `mem_wr_en` (except for a bit test).
- R7: `done` is a one-cycle pulse. A `start` that arrives while an operation is in progress is ignored.
- R8: A synchronous `rst` drops any pending operation: no later `done` and no write is produced for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an operation with `opcode` |
| opcode | input | 8 | Second instruction byte |
| hl_pair | input | ADDR_W | Current H:L value used as memory address |
| rf_rd_sel | output | 3 | Register read select |
| rf_rd_data | input | 8 | Register read data, same cycle |
| rf_wr_en | output | 1 | Register write strobe |
| rf_wr_sel | output | 3 | Register write select |
| rf_wr_data | output | 8 | Register write data |
| mem_rd_en | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Memory address |
| mem_rd_data | input | 8 | Memory read data, one cycle after request |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_data | output | 8 | Memory write data |
| flags_in | input | 4 | Current flags {Z,N,H,C} |
| flags_out | output | 4 | New flags {Z,N,H,C} |
| flags_wr_en | output | 1 | Flag write strobe |
| done | output | 1 | Operation finishing this cycle |

## Verification
The assertions rely on these properties of the inputs:
- The register file returns the selected byte in the same cycle.
- Memory returns data exactly one cycle after `mem_rd_en`.
- `hl_pair` and `flags_in` hold steady while an operation is in progress.

The bench's environment is built to those rules. It reads the register array combinationally, registers the memory byte on the clock after a read request, and only updates registers, memory and flags from the unit's write strobes or between operations. Deliberate violations are limited to a `start` held across a busy cycle and a reset in the middle of an operation; both are covered by R7 and R8.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

    localparam int DATA_W = 8;
    localparam int SEL_W  = 3;
    localparam int FLAG_W = 4;
    localparam logic [SEL_W-1:0] MEM_SEL = 3'd6;

    typedef enum logic [1:0] {
        GRP_SHIFT = 2'b00,
        GRP_TEST  = 2'b01,
        GRP_CLR   = 2'b10,
        GRP_SETB  = 2'b11
    } grp_e;

    typedef enum logic [2:0] {
        SH_RLC  = 3'd0,
        SH_RRC  = 3'd1,
        SH_RL   = 3'd2,
        SH_RR   = 3'd3,
        SH_SLA  = 3'd4,
        SH_SRA  = 3'd5,
        SH_SWAP = 3'd6,
        SH_SRL  = 3'd7
    } shop_e;

    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } flags_t;

    typedef struct packed {
        grp_e             grp;
        logic [2:0]       sub;
        logic [SEL_W-1:0] sel;
    } dec_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REG  = 2'd1,
        ST_MRD  = 2'd2,
        ST_MWB  = 2'd3
    } state_e;

endpackage

// File: rtl/bitop_decode.sv
module bitop_decode
    import bitop_pkg::*;
(
    input  logic [7:0] opcode,
    output dec_t       dec,
    output logic       is_mem
);
    always_comb begin
        dec.grp = grp_e'(opcode[7:6]);
        dec.sub = opcode[5:3];
        dec.sel = opcode[2:0];
        is_mem  = (opcode[2:0] == MEM_SEL);
    end
endmodule

// File: rtl/bitop_alu.sv
module bitop_alu
    import bitop_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  grp_e         grp,
    input  logic [2:0]   sub,
    input  logic [W-1:0] operand,
    input  flags_t       fl_in,
    output logic [W-1:0] result,
    output flags_t       fl_out,
    output logic         wr_result,
    output logic         wr_flags
);
    localparam int HALF = W / 2;

    logic [W-1:0] idx_mask;
    logic [W-1:0] sh_res;
    logic         sh_co;

    genvar g;
    generate
        for (g = 0; g < W; g++) begin : g_mask
            assign idx_mask[g] = (sub == g[2:0]);
        end
    endgenerate

    always_comb begin
        sh_res = operand;
        sh_co  = 1'b0;
        case (shop_e'(sub))
            SH_RLC:  begin sh_res = {operand[W-2:0], operand[W-1]}; sh_co = operand[W-1]; end
            SH_RRC:  begin sh_res = {operand[0], operand[W-1:1]};   sh_co = operand[0];   end
            SH_RL:   begin sh_res = {operand[W-2:0], fl_in.c};      sh_co = operand[W-1]; end
            SH_RR:   begin sh_res = {fl_in.c, operand[W-1:1]};      sh_co = operand[0];   end
            SH_SLA:  begin sh_res = {operand[W-2:0], 1'b0};         sh_co = operand[W-1]; end
            SH_SRA:  begin sh_res = {operand[W-1], operand[W-1:1]}; sh_co = operand[0];   end
            SH_SWAP: begin sh_res = {operand[HALF-1:0], operand[W-1:HALF]}; sh_co = 1'b0; end
            default: begin sh_res = {1'b0, operand[W-1:1]};         sh_co = operand[0];   end
        endcase
    end

    always_comb begin
        result    = operand;
        fl_out    = fl_in;
        wr_result = 1'b0;
        wr_flags  = 1'b0;
        case (grp)
            GRP_SHIFT: begin
                result    = sh_res;
                fl_out.z  = (sh_res == '0);
                fl_out.n  = 1'b0;
                fl_out.h  = 1'b0;
                fl_out.c  = sh_co;
                wr_result = 1'b1;
                wr_flags  = 1'b1;
            end
            GRP_TEST: begin
                fl_out.z  = ~|(operand & idx_mask);
                fl_out.n  = 1'b0;
                fl_out.h  = 1'b1;
                wr_flags  = 1'b1;
            end
            GRP_CLR: begin
                result    = operand & ~idx_mask;
                wr_result = 1'b1;
            end
            default: begin
                result    = operand | idx_mask;
                wr_result = 1'b1;
            end
        endcase
    end

    // Rotations without carry and the nibble exchange keep the bit population.
    always_comb begin
        if (grp == GRP_SHIFT && (sub == SH_RLC || sub == SH_RRC || sub == SH_SWAP)) begin
            assert_rot_keeps_bits_R2: assert ($countones(result) == $countones(operand));
        end
    end
endmodule

// File: rtl/bitop_exec.sv
module bitop_exec
    import bitop_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [7:0]        opcode,
    input  logic [ADDR_W-1:0] hl_pair,
    output logic [2:0]        rf_rd_sel,
    input  logic [7:0]        rf_rd_data,
    output logic              rf_wr_en,
    output logic [2:0]        rf_wr_sel,
    output logic [7:0]        rf_wr_data,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_rd_data,
    output logic              mem_wr_en,
    output logic [7:0]        mem_wr_data,
    input  logic [3:0]        flags_in,
    output logic [3:0]        flags_out,
    output logic              flags_wr_en,
    output logic              done
);
    typedef struct packed {
        state_e st;
        dec_t   dec;
    } ctl_t;

    ctl_t   ctl_d, ctl_q;
    dec_t   dec_w;
    logic   is_mem_w;
    logic [DATA_W-1:0] operand, alu_res;
    flags_t alu_fl;
    logic   alu_wr_res, alu_wr_fl;
    logic   finishing;

    bitop_decode u_dec (
        .opcode (opcode),
        .dec    (dec_w),
        .is_mem (is_mem_w)
    );

    always_comb begin
        ctl_d = ctl_q;
        case (ctl_q.st)
            ST_IDLE: begin
                if (start) begin
                    ctl_d.dec = dec_w;
                    ctl_d.st  = is_mem_w ? ST_MRD : ST_REG;
                end
            end
            ST_MRD:  ctl_d.st = ST_MWB;
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '{st: ST_IDLE, dec: '{grp: GRP_SHIFT, sub: 3'd0, sel: 3'd0}};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign operand = (ctl_q.st == ST_MWB) ? mem_rd_data : rf_rd_data;

    bitop_alu #(.W(DATA_W)) u_alu (
        .grp       (ctl_q.dec.grp),
        .sub       (ctl_q.dec.sub),
        .operand   (operand),
        .fl_in     (flags_t'(flags_in)),
        .result    (alu_res),
        .fl_out    (alu_fl),
        .wr_result (alu_wr_res),
        .wr_flags  (alu_wr_fl)
    );

    assign finishing   = (ctl_q.st == ST_REG) || (ctl_q.st == ST_MWB);
    assign done        = finishing;
    assign rf_rd_sel   = ctl_q.dec.sel;
    assign rf_wr_sel   = ctl_q.dec.sel;
    assign rf_wr_data  = alu_res;
    assign rf_wr_en    = (ctl_q.st == ST_REG) && alu_wr_res;
    assign mem_rd_en   = (ctl_q.st == ST_MRD);
    assign mem_addr    = hl_pair;
    assign mem_wr_data = alu_res;
    assign mem_wr_en   = (ctl_q.st == ST_MWB) && alu_wr_res;
    assign flags_out   = alu_fl;
    assign flags_wr_en = finishing && alu_wr_fl;

    assert_reg_target_R1: assert property (@(posedge clk) disable iff (rst)
        rf_wr_en |-> (rf_wr_sel != MEM_SEL) && done);

    assert_reg_one_cycle_R1: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.st == ST_REG) |=> (ctl_q.st == ST_IDLE));

    assert_rmw_order_R6: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |-> $past(mem_rd_en));

    assert_single_read_R6: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |=> !mem_rd_en && done);

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_reset_clears_R8: assert property (@(posedge clk)
        rst |=> !done && !mem_wr_en && !rf_wr_en);
endmodule

// File: tb/bitop_exec_tb_top.sv
`timescale 1ns/1ps
module bitop_exec_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  opcode = 8'h00;
    logic [15:0] hl_pair;
    logic [2:0]  rf_rd_sel, rf_wr_sel;
    logic [7:0]  rf_rd_data, rf_wr_data, mem_rd_data, mem_wr_data;
    logic        rf_wr_en, mem_rd_en, mem_wr_en, flags_wr_en, done;
    logic [15:0] mem_addr;
    logic [3:0]  flags_out;

    logic [7:0]  rf  [8];
    logic [7:0]  mem [256];
    logic [3:0]  flg = 4'h0;
    logic [7:0]  mrd_q = 8'h00;
    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    assign rf_rd_data  = rf[rf_rd_sel];
    assign hl_pair     = {rf[4], rf[5]};
    assign mem_rd_data = mrd_q;

    always @(posedge clk) begin
        if (rf_wr_en)    rf[rf_wr_sel] <= rf_wr_data;
        if (mem_wr_en)   mem[mem_addr[7:0]] <= mem_wr_data;
        if (mem_rd_en)   mrd_q <= mem[mem_addr[7:0]];
        if (flags_wr_en) flg <= flags_out;
    end

    bitop_exec #(.ADDR_W(16)) dut_i (
        .clk(clk), .rst(rst), .start(start), .opcode(opcode), .hl_pair(hl_pair),
        .rf_rd_sel(rf_rd_sel), .rf_rd_data(rf_rd_data), .rf_wr_en(rf_wr_en),
        .rf_wr_sel(rf_wr_sel), .rf_wr_data(rf_wr_data), .mem_rd_en(mem_rd_en),
        .mem_addr(mem_addr), .mem_rd_data(mem_rd_data), .mem_wr_en(mem_wr_en),
        .mem_wr_data(mem_wr_data), .flags_in(flg), .flags_out(flags_out),
        .flags_wr_en(flags_wr_en), .done(done)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference: returns {wr_res, wr_flags, result[7:0], flags[3:0]}
    function automatic logic [13:0] ref_op(input logic [7:0] op, input logic [7:0] v, input logic [3:0] f);
        int grp = op / 64;
        int k   = (op / 8) % 8;
        int vi  = v;
        int ci  = f[0];
        int r   = vi;
        int co  = 0;
        logic [3:0] nf = f;
        bit wr = 0, wf = 0;
        if (grp == 0) begin
            case (k)
                0: begin co = vi / 128; r = (vi * 2) % 256 + co; end
                1: begin co = vi % 2;   r = vi / 2 + co * 128; end
                2: begin co = vi / 128; r = (vi * 2) % 256 + ci; end
                3: begin co = vi % 2;   r = vi / 2 + ci * 128; end
                4: begin co = vi / 128; r = (vi * 2) % 256; end
                5: begin co = vi % 2;   r = vi / 2 + (vi / 128) * 128; end
                6: begin co = 0;        r = (vi % 16) * 16 + vi / 16; end
                default: begin co = vi % 2; r = vi / 2; end
            endcase
            nf = {(r == 0), 1'b0, 1'b0, co[0]};
            wr = 1; wf = 1;
        end else if (grp == 1) begin
            nf = {((vi >> k) % 2 == 0), 1'b0, 1'b1, f[0]};
            wf = 1;
        end else if (grp == 2) begin
            if ((vi >> k) % 2 == 1) r = vi - (1 << k);
            wr = 1;
        end else begin
            if ((vi >> k) % 2 == 0) r = vi + (1 << k);
            wr = 1;
        end
        return {wr, wf, r[7:0], nf};
    endfunction

    task automatic do_op(input logic [7:0] op, input logic [7:0] val, input string tag);
        logic [2:0]  sel = op[2:0];
        logic [13:0] e;
        logic [3:0]  f0;
        logic [7:0]  act, expv;
        int lat = (sel == 3'd6) ? 2 : 1;
        if (sel == 3'd6) mem[rf[5]] = val; else rf[sel] = val;
        f0 = flg;
        e = ref_op(op, val, f0);
        opcode = op;
        start = 1'b1;
        for (int k = 1; k <= lat; k++) begin
            @(negedge clk);
            if (k == 1) start = 1'b0;
            chk(done == (k == lat), {tag, " done timing (R1/R6)"}, done, (k == lat));
        end
        @(negedge clk);
        chk(done == 1'b0, {tag, " done pulse R7"}, done, 0);
        act  = (sel == 3'd6) ? mem[rf[5]] : rf[sel];
        expv = e[13] ? e[11:4] : val;
        chk(act == expv, {tag, " result"}, act, expv);
        chk(flg == (e[12] ? e[3:0] : f0), {tag, " flags"}, flg, (e[12] ? e[3:0] : f0));
    endtask

    initial begin
        logic [15:0] lf = 16'hACE1;
        for (int i = 0; i < 8; i++) rf[i] = 8'(i * 17);
        for (int i = 0; i < 256; i++) mem[i] = 8'(i ^ 8'h5A);
        repeat (3) @(negedge clk);
        chk(!done && !rf_wr_en && !mem_wr_en && !flags_wr_en && !mem_rd_en,
            "reset state R8", {done, rf_wr_en, mem_wr_en, flags_wr_en}, 0);
        rst = 1'b0;
        @(negedge clk);

        // R2/R3 shift group on registers with both carry values
        for (int k = 0; k < 8; k++) begin
            flg = 4'h0; do_op(8'(k * 8 + 1), 8'h81, "R2 shift C=0");
            flg = 4'h1; do_op(8'(k * 8 + 7), 8'h80, "R3 shift C=1");
            flg = 4'h1; do_op(8'(k * 8 + 3), 8'h00, "R3 zero result");
        end
        flg = 4'h0; do_op(8'h37, 8'hF0, "R2 swap A");
        flg = 4'h1; do_op(8'h2F, 8'h81, "R2 sra keeps bit7");
        // R4 bit tests, set and clear bits, carry both ways
        flg = 4'h1; do_op(8'h7F, 8'h80, "R4 test set bit");
        flg = 4'h0; do_op(8'h47, 8'hFE, "R4 test clear bit");
        flg = 4'hA; do_op(8'h5A, 8'h08, "R4 test D bit3");
        // R5 reset/set with flags untouched
        flg = 4'hF; do_op(8'hBF, 8'hFF, "R5 clear bit7 A");
        flg = 4'h5; do_op(8'hC0, 8'h00, "R5 set bit0 B");
        flg = 4'h9; do_op(8'h99, 8'h08, "R5 clear bit3 C");
        // R6 memory forms
        rf[4] = 8'h12; rf[5] = 8'h34;
        flg = 4'h0; do_op(8'h06, 8'h81, "R6 mem rlc");
        flg = 4'h1; do_op(8'h1E, 8'h02, "R6 mem rr");
        flg = 4'h0; do_op(8'h76, 8'h40, "R6 mem bit test no write");
        flg = 4'h3; do_op(8'hFE, 8'h00, "R6 mem set7");
        flg = 4'h3; do_op(8'hB6, 8'hFF, "R6 mem clr6");

        // R7: start held while busy is ignored
        mem[8'h34] = 8'h81; flg = 4'h0; opcode = 8'h06; start = 1'b1;
        @(negedge clk); chk(done == 0, "R7 busy cycle1", done, 0);
        @(negedge clk); start = 1'b0; chk(done == 1, "R7 busy done", done, 1);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); chk(done == 0, "R7 no second done", done, 0);
        end
        chk(mem[8'h34] == 8'h03, "R7 single rotate", mem[8'h34], 8'h03);

        // R8: reset mid memory operation
        mem[8'h34] = 8'h00; opcode = 8'hFE; start = 1'b1;
        @(negedge clk); start = 1'b0; rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        for (int k = 0; k < 4; k++) begin
            chk(done == 0 && !mem_wr_en, "R8 no done after reset", done, 0);
            @(negedge clk);
        end
        chk(mem[8'h34] == 8'h00, "R8 memory untouched", mem[8'h34], 0);

        // Pseudo-random sweep over all groups (R1..R6)
        for (int n = 0; n < 400; n++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            flg = lf[11:8];
            rf[4] = 8'h12; rf[5] = 8'(lf[15:12]);
            do_op(lf[7:0], lf[15:8] ^ lf[7:0], "R1 sweep");
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule